// File: doc/BRIEF.md
# Edge-Selectable Event Capture Register

This block collects 32 event lines and turns transitions on them into pending flags for a downstream priority encoder. Most lines come from peripherals and are asynchronous to the block clock. Ten positions are instead fed from a software trigger register, so a CPU can raise an event by toggling a bit. A live level view shows the current state of every event line. A separate flag vector records that the chosen edge has occurred on a line.

Each position has its own edge polarity bit and its own enable bit. A flag stays set until the encoder clears it with a per-bit clear, or until the CPU clears it with a write-1-to-clear. If a new edge and a clear reach the same bit in the same cycle, the edge wins. Position 25 is reserved and can never be flagged.

The register port is a plain single-cycle control interface with no back-pressure: a write takes effect at the clock edge where `reg_wr_i` is high, and `reg_rdata_o` is a combinational view of the register selected by `reg_addr_i`. The pending vector is a level output. The encoder consumes a flag by pulsing the matching bit of `enc_clr_i`, so no handshake is needed.

Top module: `edge_event_capture`

## Requirements
- R1: Every peripheral-fed position of the level register (address 0) equals that peripheral input as it was two clock cycles earlier. A change on the input appears in the level register after two edges and in the flag after three.
- R2: When a position's polarity bit is 1, a 0-to-1 transition of its level bit sets its flag, and a 1-to-0 transition does not.
- R3: When a position's polarity bit is 0, a 1-to-0 transition of its level bit sets its flag, and a 0-to-1 transition does not.
- R4: Trigger register (address 4) bits 21, 20, 19, 18, 17, 16, 3, 2, 1 and 0 drive event positions 31, 30, 24, 18, 11, 1, 23, 17, 10 and 0, in that order. The peripheral inputs at those positions have no effect, and the other trigger bits raise no event.
- R5: Writing a trigger bit with the value it already holds produces no event.
- R6: Position 25 never sets its flag, and its level bit always reads 0.
- R7: Any number of flags that are set in the same cycle are all held.
- R8: A flag stays set until it is cleared, either by a 1 on the matching bit of `enc_clr_i` or by writing 1 to that bit of the flag register (address 1). Written 0 bits leave their flags unchanged.
- R9: If an edge sets a bit in the same cycle that the bit is cleared, the flag ends up set.
- R10: An enable bit (address 3) of 0 stops its flag from being set but does not mask the level bit. Enabling a position later does not flag an edge that happened while it was disabled.
- R11: After reset, level, flag, enable and trigger read 0 and polarity (address 2) reads all ones. Polarity, enable and trigger read back the value written last. Writes to the level address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_evt_i | input | 32 | Raw asynchronous peripheral event lines, one per position |
| reg_addr_i | input | 3 | Register select: 0 level, 1 flag, 2 polarity, 3 enable, 4 trigger |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data of the selected register |
| enc_clr_i | input | 32 | Per-bit flag clear from the downstream encoder |
| pend_o | output | 32 | Pending event flag vector |

## Verification
The capture path is driven with a walking one across all 32 peripheral lines, which separates working positions from those owned by software and from the reserved slot. A walking one is then driven across all 32 trigger bits, which checks the exact scatter of the trigger bits and shows that unmapped bits are inert. All-lines-high followed by all-lines-low under falling polarity shows that simultaneous flags are kept, and that the edge opposite to the chosen one is ignored. Targeted sequences cover a rewrite of an unchanged trigger value, a clear that coincides with an edge, a flag write that mixes ones and zeros, and an edge that arrives while its position is disabled.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  localparam int unsigned EVT_COUNT    = 32;
  localparam int unsigned RESERVED_EVT = 25;
  localparam int unsigned REG_ADDR_W   = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_FLAG  = 3'd1,
    SEL_POL   = 3'd2,
    SEL_EN    = 3'd3,
    SEL_TRIG  = 3'd4
  } reg_sel_e;

  // Software trigger bit that feeds an event position, or -1 when the
  // position is fed by a peripheral line.
  function automatic int sw_source(input int unsigned evt);
    case (evt)
      0:       return 0;
      1:       return 16;
      10:      return 1;
      11:      return 17;
      17:      return 2;
      18:      return 18;
      23:      return 3;
      24:      return 19;
      30:      return 20;
      31:      return 21;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned AGE_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

  // Cycles since reset, saturating; lets the check below look back safely.
  logic [AGE_W-1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)                      age <= '0;
    else if (age < AGE_W'(STAGES))   age <= age + 1'b1;
  end

  // R1
  level_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == AGE_W'(STAGES)) |-> (sync_o == $past(async_i, STAGES)));

endmodule

// File: rtl/evcap_merge.sv
module evcap_merge
  import evcap_pkg::*;
#(
  parameter int unsigned EVT_N  = EVT_COUNT,
  parameter int unsigned RSVD   = RESERVED_EVT
) (
  input  logic [EVT_N-1:0] sync_i,
  input  logic [EVT_N-1:0] trig_i,
  output logic [EVT_N-1:0] level_o
);

  generate
    for (genvar e = 0; e < EVT_N; e++) begin : g_pos
      localparam int SRC = sw_source(e);
      if (SRC >= 0) begin : g_soft
        assign level_o[e] = trig_i[SRC];
      end else if (e == RSVD) begin : g_rsvd
        assign level_o[e] = 1'b0;
      end else begin : g_hw
        assign level_o[e] = sync_i[e];
      end
    end
  endgenerate

  // Inputs that feed no position are intentionally dropped.
  logic unused_inputs;
  assign unused_inputs = ^{sync_i, trig_i};

endmodule

// File: rtl/evcap_flags.sv
module evcap_flags #(
  parameter int unsigned EVT_N = 32,
  parameter int unsigned RSVD  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] level_i,
  input  logic [EVT_N-1:0] pol_i,
  input  logic [EVT_N-1:0] en_i,
  input  logic [EVT_N-1:0] clr_i,
  output logic [EVT_N-1:0] pend_o
);

  localparam logic [EVT_N-1:0] KEEP_MASK = ~(EVT_N'(1) << RSVD);

  logic [EVT_N-1:0] prev_q;
  logic [EVT_N-1:0] rise, fall, hit, set_v;
  logic [EVT_N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign rise  = level_i & ~prev_q;
  assign fall  = ~level_i & prev_q;
  assign hit   = (pol_i & rise) | (~pol_i & fall);
  assign set_v = hit & en_i & KEEP_MASK;

  // Setting has priority over clearing within the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_v;
  end

  assign pend_o = pend_q;

  // R6
  rsvd_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[RSVD] == 1'b0);

  // R10
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~$past(pend_o) & ~$past(en_i)) == '0);

  // R8
  clear_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_i & ~en_i) & pend_o) == '0);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_o & ~clr_i) & ~pend_o) == '0);

endmodule

// File: rtl/edge_event_capture.sv
module edge_event_capture
  import evcap_pkg::*;
#(
  parameter int unsigned EVT_N       = EVT_COUNT,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RSVD        = RESERVED_EVT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EVT_N-1:0]      periph_evt_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [EVT_N-1:0]      reg_wdata_i,
  output logic [EVT_N-1:0]      reg_rdata_o,
  input  logic [EVT_N-1:0]      enc_clr_i,
  output logic [EVT_N-1:0]      pend_o
);

  reg_sel_e         sel;
  logic [EVT_N-1:0] pol_q, en_q, trig_q;
  logic [EVT_N-1:0] sync_evt, level, w1c, clr_all;

  assign sel = reg_sel_e'(reg_addr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= '1;
      en_q   <= '0;
      trig_q <= '0;
    end else if (reg_wr_i) begin
      case (sel)
        SEL_POL:  pol_q  <= reg_wdata_i;
        SEL_EN:   en_q   <= reg_wdata_i;
        SEL_TRIG: trig_q <= reg_wdata_i;
        default:  ;
      endcase
    end
  end

  assign w1c     = (reg_wr_i && sel == SEL_FLAG) ? reg_wdata_i : '0;
  assign clr_all = enc_clr_i | w1c;

  evcap_sync #(.WIDTH(EVT_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (periph_evt_i),
    .sync_o  (sync_evt)
  );

  evcap_merge #(.EVT_N(EVT_N), .RSVD(RSVD)) u_merge (
    .sync_i  (sync_evt),
    .trig_i  (trig_q),
    .level_o (level)
  );

  evcap_flags #(.EVT_N(EVT_N), .RSVD(RSVD)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level),
    .pol_i   (pol_q),
    .en_i    (en_q),
    .clr_i   (clr_all),
    .pend_o  (pend_o)
  );

  always_comb begin
    case (sel)
      SEL_LEVEL: reg_rdata_o = level;
      SEL_FLAG:  reg_rdata_o = pend_o;
      SEL_POL:   reg_rdata_o = pol_q;
      SEL_EN:    reg_rdata_o = en_q;
      SEL_TRIG:  reg_rdata_o = trig_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  // R5
  trig_stable_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(trig_q) && $stable(periph_evt_i) && $past($stable(periph_evt_i))
     && $past($stable(periph_evt_i), 2) && $past(trig_q == level)) |=>
    ((pend_o & ~$past(pend_o)) == '0));

endmodule

// File: tb/edge_event_capture_test.sv
module edge_event_capture_test;

  localparam logic [2:0] A_LVL = 3'd0, A_FLG = 3'd1, A_POL = 3'd2, A_EN = 3'd3, A_TRG = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] periph = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] eclr = '0;
  logic [31:0] pend;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_event_capture uut (
    .clk(clk), .rst_n(rst_n), .periph_evt_i(periph), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .enc_clr_i(eclr), .pend_o(pend)
  );

  function automatic int ev_of_trig(input int t);
    case (t)
      0: return 0;   16: return 1;  1: return 10;  17: return 11;
      2: return 17;  18: return 18; 3: return 23;  19: return 24;
      20: return 30; 21: return 31;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] trig_to_ev(input logic [31:0] tv);
    logic [31:0] r = '0;
    for (int t = 0; t < 32; t++)
      if (tv[t] && ev_of_trig(t) >= 0) r[ev_of_trig(t)] = 1'b1;
    return r;
  endfunction

  logic [31:0] soft_mask, hw_mask;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    soft_mask = trig_to_ev('1);
    hw_mask   = ~soft_mask & ~(32'd1 << 25);
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R11 reset values
    rreg(A_LVL, v); chk("R11 level reset", v, 32'h0);
    rreg(A_FLG, v); chk("R11 flag reset", v, 32'h0);
    rreg(A_POL, v); chk("R11 pol reset", v, 32'hFFFF_FFFF);
    rreg(A_EN, v);  chk("R11 en reset", v, 32'h0);
    rreg(A_TRG, v); chk("R11 trig reset", v, 32'h0);
    chk("R11 pend reset", pend, 32'h0);

    wreg(A_EN, '1);

    // R1 R2 R4 R6: walking one over peripheral lines, rising polarity
    for (int p = 0; p < 32; p++) begin
      e = hw_mask[p] ? (32'd1 << p) : 32'd0;
      periph = 32'd1 << p;
      tick(2);
      rreg(A_LVL, v); chk("R1 level after two edges (R4/R6 masked)", v, e);
      tick(1);
      rreg(A_FLG, v); chk("R2 rising flag (R4/R6 masked)", v, e);
      wreg(A_FLG, '1);
      periph = '0;
      tick(3);
      rreg(A_FLG, v); chk("R2 falling ignored", v, 32'h0);
    end

    // R3 R7: falling polarity, all lines together
    wreg(A_POL, '0);
    periph = '1;
    tick(3);
    rreg(A_FLG, v); chk("R3 rising ignored", v, 32'h0);
    rreg(A_LVL, v); chk("R6 level bit 25 zero", v, hw_mask);
    periph = '0;
    tick(3);
    rreg(A_FLG, v); chk("R7 all falling flags held", v, hw_mask);
    tick(4);
    chk("R7 flags still held", pend, hw_mask);
    wreg(A_FLG, '1);
    rreg(A_FLG, v); chk("R8 w1c all", v, 32'h0);
    wreg(A_POL, '1);

    // R4: walking one over trigger bits
    for (int t = 0; t < 32; t++) begin
      e = (ev_of_trig(t) >= 0) ? (32'd1 << ev_of_trig(t)) : 32'd0;
      wreg(A_TRG, 32'd1 << t);
      rreg(A_LVL, v); chk("R4 trigger level map", v, e);
      tick(1);
      rreg(A_FLG, v); chk("R4 trigger flag map", v, e);
      wreg(A_TRG, '0);
      wreg(A_FLG, '1);
      tick(1);
      rreg(A_FLG, v); chk("R4 trigger fall ignored", v, 32'h0);
    end

    // R5: rewrite of unchanged trigger value
    wreg(A_TRG, 32'h1);
    tick(1);
    wreg(A_FLG, '1);
    wreg(A_TRG, 32'h1);
    tick(1);
    rreg(A_FLG, v); chk("R5 unchanged trigger", v, 32'h0);
    wreg(A_TRG, '0);
    tick(1);

    // R7: all ten software events in one write
    wreg(A_TRG, 32'h003F_000F);
    tick(1);
    rreg(A_FLG, v); chk("R7 simultaneous trigger flags", v, soft_mask);
    wreg(A_TRG, '0);
    wreg(A_FLG, '1);

    // R9: edge and encoder clear in same cycle
    wreg(A_TRG, 32'h1);
    eclr = 32'h1;
    tick(1);
    eclr = '0;
    rreg(A_FLG, v); chk("R9 edge beats clear", v, 32'h1);
    // R8: encoder clear alone
    eclr = 32'h1;
    tick(1);
    eclr = '0;
    rreg(A_FLG, v); chk("R8 encoder clear", v, 32'h0);
    // R8: w1c with zero bits
    wreg(A_TRG, '0);
    wreg(A_TRG, 32'h1);
    tick(1);
    wreg(A_FLG, 32'hFFFF_FFFE);
    rreg(A_FLG, v); chk("R8 zero bits keep flag", v, 32'h1);
    wreg(A_FLG, 32'h1);
    rreg(A_FLG, v); chk("R8 w1c single bit", v, 32'h0);
    wreg(A_TRG, '0);

    // R10: enable mask
    wreg(A_EN, ~(32'd1 << 4));
    periph = 32'd1 << 4;
    tick(3);
    rreg(A_FLG, v); chk("R10 disabled no flag", v, 32'h0);
    rreg(A_LVL, v); chk("R10 level unmasked", v, 32'd1 << 4);
    wreg(A_EN, '1);
    tick(2);
    rreg(A_FLG, v); chk("R10 no retroactive flag", v, 32'h0);
    periph = '0;
    tick(3);

    // R11 readback and read-only level
    wreg(A_POL, 32'h1234_ABCD);
    rreg(A_POL, v); chk("R11 pol readback", v, 32'h1234_ABCD);
    wreg(A_EN, 32'h0F0F_5A5A);
    rreg(A_EN, v);  chk("R11 en readback", v, 32'h0F0F_5A5A);
    wreg(A_TRG, 32'hC0FF_EE00);
    rreg(A_TRG, v); chk("R11 trig readback", v, 32'hC0FF_EE00);
    wreg(A_LVL, '1);
    rreg(A_LVL, v); chk("R11 level write ignored", v, trig_to_ev(32'hC0FF_EE00));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule